// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the instruction address of a single-cycle processor and works out the following address in every clock cycle. The register has no load enable: each rising edge outside reset replaces it with the selected next value, and its output goes straight to the instruction memory address.

Three candidate values are formed in parallel. The sequential value is the current address plus four. The relative branch value adds the sign-extended 16-bit offset field, scaled by four, to that incremented address. The absolute jump value keeps the top bits of the incremented address, places the 26-bit target field beneath them, and appends two zero bits. The control decoder supplies a branch flag and a jump flag. The ALU supplies an equality result. The offset and target fields come straight from the current instruction word.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the address output to 0x00000000 on the next rising edge, whatever the other inputs are.
- R2: When neither the branch flag nor the jump flag is set, every rising edge advances the address by 4. There is no input that holds the address.
- R3: When the branch flag and the equality input are both 1 and the jump flag is 0, the next address is current+4 plus the 16-bit offset (bit 15 is its sign) sign-extended and multiplied by 4, modulo 2^32.
- R4: When the branch flag is 1 and the equality input is 0 and the jump flag is 0, the next address is current+4.
- R5: When the jump flag is 1, the next address is bits 31..28 of current+4 in bits 31..28, the 26-bit target field in bits 27..2, and zero in bits 1..0.
- R6: The jump flag takes priority over a taken branch. With all three of branch, equality and jump set, the jump address is used.
- R7: A taken branch with offset 0xFFFF leaves the address unchanged.
- R8: The equality input has no effect while the branch flag is 0. The address still advances by 4.
- R9: The address wraps modulo 2^32. An increment from 0xFFFFFFFC gives 0, and a jump from there takes its top bits from that wrapped value (region 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the address updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| branch_en | input | 1 | Instruction is a conditional branch |
| jump_en | input | 1 | Instruction is an absolute jump |
| alu_equal | input | 1 | Equality result of the two compared operands |
| offset_field | input | 16 | Signed word offset from the instruction |
| target_field | input | 26 | Word target from the instruction |
| pc_out | output | 32 | Current instruction address |

## Verification
Every result appears exactly one rising edge after the inputs that select it. The output is the register itself, so a change is visible right after that edge. The bench drives the flags and fields on the falling edge, lets one rising edge pass, and compares the address on the next falling edge. Each expected value therefore belongs to one instruction alone. Reset is checked the same way: it is asserted on a falling edge and takes effect at the following rising edge.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    // Which candidate feeds the address register.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } next_src_e;

    // Bytes per instruction word; the increment and both scalings use it.
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/pc_seq_incr.sv
module pc_seq_incr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] sum_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb begin
        sum_o = base_i + STEP_V;
    end
endmodule

// File: rtl/pc_seq_rel.sv
module pc_seq_rel #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] dest_o
);
    localparam int unsigned EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] ofs_bytes;

    always_comb begin
        ofs_ext   = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
        ofs_bytes = ofs_ext << SHIFT;
        dest_o    = seq_i + ofs_bytes;
    end
endmodule

// File: rtl/pc_seq_abs.sv
module pc_seq_abs #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TGT_W  = 26,
    parameter int unsigned SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [TGT_W-1:0]  tgt_i,
    output logic [ADDR_W-1:0] dest_o
);
    localparam int unsigned REGION_W = ADDR_W - TGT_W - SHIFT;

    generate
        if (REGION_W > 0) begin : g_region
            always_comb begin
                dest_o = {seq_i[ADDR_W-1 -: REGION_W], tgt_i, {SHIFT{1'b0}}};
            end
        end else begin : g_flat
            always_comb begin
                dest_o = ADDR_W'({tgt_i, {SHIFT{1'b0}}});
            end
        end
    endgenerate
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned TGT_W  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              branch_en,
    input  logic              jump_en,
    input  logic              alu_equal,
    input  logic [OFS_W-1:0]  offset_field,
    input  logic [TGT_W-1:0]  target_field,
    output logic [ADDR_W-1:0] pc_out
);
    import pc_seq_pkg::*;

    localparam int unsigned REGION_W = ADDR_W - TGT_W - WORD_SHIFT;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } seq_state_t;

    seq_state_t state_d, state_q;
    next_src_e  src_d;

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_addr;
    logic [ADDR_W-1:0] abs_addr;

    pc_seq_incr #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) i_incr (
        .base_i (state_q.pc),
        .sum_o  (seq_addr)
    );

    pc_seq_rel #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SHIFT(WORD_SHIFT)) i_rel (
        .seq_i  (seq_addr),
        .ofs_i  (offset_field),
        .dest_o (rel_addr)
    );

    pc_seq_abs #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .SHIFT(WORD_SHIFT)) i_abs (
        .seq_i  (seq_addr),
        .tgt_i  (target_field),
        .dest_o (abs_addr)
    );

    // Next-state logic: the jump is tested first, then the taken branch.
    always_comb begin
        if (jump_en)
            src_d = SRC_JUMP;
        else if (branch_en && alu_equal)
            src_d = SRC_BRANCH;
        else
            src_d = SRC_SEQ;

        state_d = state_q;
        unique case (src_d)
            SRC_JUMP:   state_d.pc = abs_addr;
            SRC_BRANCH: state_d.pc = rel_addr;
            default:    state_d.pc = seq_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign pc_out = state_q.pc;

    // Checks on the address sequence.
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> pc_out == '0);

    assert_plain_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!branch_en && !jump_en) |=> pc_out == $past(pc_out) + STEP_V);

    assert_taken_branch_R3: assert property (@(posedge clk) disable iff (rst)
        (branch_en && alu_equal && !jump_en) |=>
        pc_out == $past(pc_out) + STEP_V
                  + (ADDR_W'($signed($past(offset_field))) << WORD_SHIFT));

    assert_untaken_branch_R4: assert property (@(posedge clk) disable iff (rst)
        (branch_en && !alu_equal && !jump_en) |=> pc_out == $past(pc_out) + STEP_V);

    assert_jump_fields_R5: assert property (@(posedge clk) disable iff (rst)
        jump_en |=> (pc_out[TGT_W+WORD_SHIFT-1:WORD_SHIFT] == $past(target_field))
                 && (pc_out[WORD_SHIFT-1:0] == '0)
                 && (pc_out[ADDR_W-1 -: REGION_W] == $past(seq_addr[ADDR_W-1 -: REGION_W])));

    assert_jump_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (jump_en && branch_en && alu_equal) |=>
        pc_out[TGT_W+WORD_SHIFT-1:WORD_SHIFT] == $past(target_field));

    assert_self_branch_R7: assert property (@(posedge clk) disable iff (rst)
        (branch_en && alu_equal && !jump_en && (&offset_field)) |=>
        pc_out == $past(pc_out));

    assert_equal_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (!branch_en && !jump_en && alu_equal) |=> pc_out == $past(pc_out) + STEP_V);

    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (!branch_en && !jump_en && (&pc_out[ADDR_W-1:WORD_SHIFT])) |=> pc_out == '0);

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst;
    logic        branch_en;
    logic        jump_en;
    logic        alu_equal;
    logic [15:0] offset_field;
    logic [25:0] target_field;
    logic [31:0] pc_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk          (clk),
        .rst          (rst),
        .branch_en    (branch_en),
        .jump_en      (jump_en),
        .alu_equal    (alu_equal),
        .offset_field (offset_field),
        .target_field (target_field),
        .pc_out       (pc_out)
    );

    typedef struct packed {
        logic        br;
        logic        jp;
        logic        eq;
        logic [15:0] ofs;
        logic [25:0] tgt;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // The rows run in order, starting from address 0 just after reset.
    localparam vec_t VECS [11] = '{
        '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0000_0004, 8'd2}, // R2
        '{1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000000, 32'h0000_0008, 8'd8}, // R8
        '{1'b1, 1'b0, 1'b0, 16'h0010, 26'h0000000, 32'h0000_000C, 8'd4}, // R4
        '{1'b1, 1'b0, 1'b1, 16'h0004, 26'h0000000, 32'h0000_0020, 8'd3}, // R3
        '{1'b1, 1'b0, 1'b1, 16'hFFFF, 26'h0000000, 32'h0000_0020, 8'd7}, // R7
        '{1'b1, 1'b1, 1'b1, 16'h0005, 26'h0000100, 32'h0000_0400, 8'd6}, // R6
        '{1'b1, 1'b0, 1'b1, 16'hFFF0, 26'h0000000, 32'h0000_03C4, 8'd3}, // R3
        '{1'b0, 1'b1, 1'b0, 16'h0000, 26'h3FFFFFF, 32'h0FFF_FFFC, 8'd5}, // R5
        '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h1000_0000, 8'd2}, // R2
        '{1'b0, 1'b1, 1'b0, 16'h0000, 26'h0000001, 32'h1000_0004, 8'd5}, // R5
        '{1'b1, 1'b0, 1'b1, 16'h8000, 26'h0000000, 32'h0FFE_0008, 8'd3}  // R3
    };

    task automatic check(input logic [31:0] exp, input string req);
        total++;
        if (pc_out !== exp) begin
            bad++;
            $display("FAIL %s: pc_out=%h expected=%h", req, pc_out, exp);
        end
    endtask

    // Inputs change on the falling edge; the result is read one falling edge later.
    task automatic step(input logic br, input logic jp, input logic eq,
                        input logic [15:0] ofs, input logic [25:0] tgt);
        branch_en    = br;
        jump_en      = jp;
        alu_equal    = eq;
        offset_field = ofs;
        target_field = tgt;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: pc_out=%h expected=completion", pc_out);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        branch_en = 1'b0; jump_en = 1'b0; alu_equal = 1'b0;
        offset_field = '0; target_field = '0;
        @(negedge clk);
        @(negedge clk);
        check(32'h0, "R1");
        rst = 1'b0;

        for (int i = 0; i < 11; i++) begin
            step(VECS[i].br, VECS[i].jp, VECS[i].eq, VECS[i].ofs, VECS[i].tgt);
            check(VECS[i].exp, $sformatf("R%0d", VECS[i].req));
        end

        // R1: reset wins over a jump that is asserted at the same time.
        branch_en = 1'b1; jump_en = 1'b1; alu_equal = 1'b1; target_field = 26'h155;
        do_reset();
        check(32'h0, "R1");

        // R9: a backward branch from 0 lands on the top word, then the increment wraps.
        step(1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0);
        check(32'hFFFF_FFFC, "R9");
        step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        check(32'h0000_0000, "R9");

        // R9: a jump from the top word takes region 0 from the wrapped address.
        step(1'b1, 1'b0, 1'b1, 16'hFFFE, 26'h0);
        check(32'hFFFF_FFFC, "R3");
        step(1'b0, 1'b1, 1'b0, 16'h0, 26'h0000005);
        check(32'h0000_0014, "R9");

        // R5: a jump from 0xFFFFFFF8 keeps region F.
        do_reset();
        step(1'b1, 1'b0, 1'b1, 16'hFFFD, 26'h0);
        check(32'hFFFF_FFF8, "R3");
        step(1'b0, 1'b1, 1'b0, 16'h0, 26'h0000002);
        check(32'hF000_0008, "R5");

        // R2: steady advance with no flags over several cycles.
        for (int k = 1; k <= 3; k++) begin
            step(1'b0, 1'b0, 1'b0, 16'hFFFF, 26'h3FFFFFF);
            check(32'hF000_0008 + 32'(4 * k), "R2");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule